// File: doc/BRIEF.md
# ADC Power-Management Sequencer

This block decides, every master-clock cycle, whether the circuitry of a sampling converter is powered, fully off, or off with only the reference left running. Two inputs set the power state together: a 2-bit power field, loaded through a simple register-write port, and a sleep pin. A power-on calibration interval runs after reset unless it is disabled. The conversion itself is outside the block, which only times it.

In the modes that power down between conversions, the falling edge of the active-low start pin requests power. The rising edge of the same pulse starts the conversion. Power is dropped again on the same edge on which the busy flag falls. A rising edge that comes before the power-up interval has run out is ignored and sets a sticky error flag.

Software can also start a conversion or a calibration through the write port, but only while the block is powered.

Top module: `adc_pwr_seq`

## Requirements
- R1: Reset sets the power field to 00. When `cal_dis_i` is low, a power-on calibration of CAL_CYC cycles follows reset. During it `cal_o` and `pwr_up_o` stay high, and neither the sleep pin nor the start pin has any effect on it or on its length.
- R2: With `cal_dis_i` high, the calibration is skipped. With field 00 and sleep low, the block comes out of reset powered down, with `cal_o` low.
- R3: Field 01, or field 00 with sleep high, keeps the block powered. After a PWRUP_CYC-cycle wake interval, `pwr_up_o` stays high, and it remains high after each conversion completes.
- R4: With field 00 and sleep low (full cycling), or with field 11 (partial cycling), a falling edge on `start_i` raises `pwr_up_o` in the next cycle.
- R5: A rising edge of `start_i` seen while powered produces a one-cycle `conv_start_o` pulse in the next cycle. `busy_o` is high for exactly CONV_CYC cycles, beginning in that same cycle.
- R6: In the two cycling modes, `pwr_up_o` falls in the same cycle that `busy_o` falls.
- R7: `ref_en_o` is low only in the full power-down states. With field 11 the block powers down with `pwr_up_o` low and `ref_en_o` high.
- R8: Field 10 forces a full power-down. Start-pin pulses and software conversion or calibration commands are ignored while it is selected.
- R9: A `start_i` rising edge that arrives during the wake interval does not start a conversion. It sets `err_o`, which stays high until the next register write.
- R10: A write is one cycle of `wr_valid_i`, carrying `wr_pm_i`, `wr_conv_i` (conversion command) and `wr_cal_i` (calibration command). A command in a write is ignored while the block is powered down, so a write of field 01 must come first and the command in a later write. Once powered, a conversion command behaves as in R5.
- R11: A software calibration run in partial-cycling mode leaves the block powered when it ends. Only a later write that selects a cycling mode powers the block down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Register write strobe |
| wr_pm_i | input | 2 | Power field carried by the write |
| wr_conv_i | input | 1 | Conversion command carried by the write |
| wr_cal_i | input | 1 | Calibration command carried by the write |
| sleep_i | input | 1 | Sleep pin, decoded together with the field |
| start_i | input | 1 | Start pin: falling edge wakes the block, rising edge converts |
| cal_dis_i | input | 1 | High skips the power-on calibration |
| pwr_up_o | output | 1 | Power request to the converter circuitry |
| ref_en_o | output | 1 | Reference enable |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| busy_o | output | 1 | Conversion in progress |
| cal_o | output | 1 | Calibration in progress |
| err_o | output | 1 | Sticky flag for a start edge that came too early |

## Verification
The bench builds the block with PWRUP_CYC=8, CONV_CYC=5 and CAL_CYC=20. This lets it measure every interval cycle by cycle, where the default calibration length would take far too long. With a short wake interval it can place a rising edge in the last wake cycle and in the first powered cycle. This checks the boundary between the ignored edge that sets the error flag and the edge that starts a conversion.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {
    MD_CYC_FULL,
    MD_ON,
    MD_OFF,
    MD_CYC_PART
  } pmode_e;

  typedef enum logic [2:0] {
    S_RST,
    S_CAL,
    S_DOWN,
    S_WAKE,
    S_ON,
    S_CONV
  } st_e;

  localparam logic [1:0] PM_RESET = 2'b00;
endpackage

// File: rtl/adc_pwr_decode.sv
module adc_pwr_decode
  import adc_pwr_pkg::*;
(
  input  logic [1:0] pm_i,
  input  logic       sleep_i,
  output pmode_e     mode_o
);
  always_comb begin
    unique case (pm_i)
      2'b00:   mode_o = sleep_i ? MD_ON : MD_CYC_FULL;
      2'b01:   mode_o = MD_ON;
      2'b10:   mode_o = MD_OFF;
      default: mode_o = MD_CYC_PART;
    endcase
  end
endmodule

// File: rtl/adc_pwr_edge.sv
module adc_pwr_edge #(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= IDLE_VAL;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
  assign fall_o = ~d_i & d_q;
endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int PWRUP_CYC = 30,
  parameter int CONV_CYC  = 21,
  parameter int CAL_CYC   = 1000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cal_dis_i,
  input  pmode_e mode_q_i,
  input  pmode_e mode_nx_i,
  input  logic   wr_valid_i,
  input  logic   wr_conv_i,
  input  logic   wr_cal_i,
  input  logic   rise_i,
  input  logic   fall_i,
  output logic   pwr_up_o,
  output logic   ref_en_o,
  output logic   conv_start_o,
  output logic   busy_o,
  output logic   cal_o,
  output logic   err_o
);
  localparam int MAX_A = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
  localparam int MAX_C = (MAX_A > CAL_CYC) ? MAX_A : CAL_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LD_WAKE = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CONV = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CAL  = CNT_W'(CAL_CYC - 1);

  st_e              st_q, st_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             tmr_done;
  logic             err_set, err_q, conv_q;
  logic             cyc_nx, sw_conv, sw_cal;

  assign cyc_nx  = (mode_nx_i == MD_CYC_FULL) || (mode_nx_i == MD_CYC_PART);
  assign sw_conv = wr_valid_i & wr_conv_i;
  assign sw_cal  = wr_valid_i & wr_cal_i;

  adc_pwr_timer #(.W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .done_o (tmr_done)
  );

  always_comb begin
    st_d    = st_q;
    ld      = 1'b0;
    ld_val  = '0;
    err_set = 1'b0;
    unique case (st_q)
      S_RST: begin
        if (cal_dis_i) st_d = S_DOWN;
        else begin
          st_d   = S_CAL;
          ld     = 1'b1;
          ld_val = LD_CAL;
        end
      end
      S_CAL: begin
        // calibration end never enters partial power-down by itself
        if (tmr_done)
          st_d = (mode_nx_i == MD_CYC_FULL || mode_nx_i == MD_OFF) ? S_DOWN : S_ON;
      end
      S_DOWN: begin
        if (mode_nx_i == MD_ON || (cyc_nx && fall_i)) begin
          st_d   = S_WAKE;
          ld     = 1'b1;
          ld_val = LD_WAKE;
        end
      end
      S_WAKE: begin
        if (mode_nx_i == MD_OFF) st_d = S_DOWN;
        else begin
          if (rise_i)   err_set = 1'b1;
          if (tmr_done) st_d = S_ON;
        end
      end
      S_ON: begin
        if (mode_nx_i == MD_OFF) st_d = S_DOWN;
        else if (sw_cal) begin
          st_d   = S_CAL;
          ld     = 1'b1;
          ld_val = LD_CAL;
        end else if (rise_i || sw_conv) begin
          st_d   = S_CONV;
          ld     = 1'b1;
          ld_val = LD_CONV;
        end else if (wr_valid_i && cyc_nx) st_d = S_DOWN;
      end
      S_CONV: begin
        if (tmr_done)
          st_d = (cyc_nx || mode_nx_i == MD_OFF) ? S_DOWN : S_ON;
      end
      default: st_d = S_RST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_RST;
      err_q  <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      conv_q <= (st_d == S_CONV) && (st_q != S_CONV);
      if (err_set)         err_q <= 1'b1;
      else if (wr_valid_i) err_q <= 1'b0;
    end
  end

  assign pwr_up_o     = (st_q == S_CAL) || (st_q == S_WAKE) || (st_q == S_ON) || (st_q == S_CONV);
  assign ref_en_o     = !(((st_q == S_DOWN) || (st_q == S_RST)) && (mode_q_i != MD_CYC_PART));
  assign conv_start_o = conv_q;
  assign busy_o       = (st_q == S_CONV);
  assign cal_o        = (st_q == S_CAL);
  assign err_o        = err_q;
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int PWRUP_CYC = 30,
  parameter int CONV_CYC  = 21,
  parameter int CAL_CYC   = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [1:0] wr_pm_i,
  input  logic       wr_conv_i,
  input  logic       wr_cal_i,
  input  logic       sleep_i,
  input  logic       start_i,
  input  logic       cal_dis_i,
  output logic       pwr_up_o,
  output logic       ref_en_o,
  output logic       conv_start_o,
  output logic       busy_o,
  output logic       cal_o,
  output logic       err_o
);
  logic [1:0] pm_q, pm_nx;
  pmode_e     mode_q, mode_nx;
  logic       rise, fall;

  assign pm_nx = wr_valid_i ? wr_pm_i : pm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pm_q <= PM_RESET;
    else         pm_q <= pm_nx;
  end

  adc_pwr_decode u_dec_q (.pm_i(pm_q),  .sleep_i(sleep_i), .mode_o(mode_q));
  adc_pwr_decode u_dec_nx(.pm_i(pm_nx), .sleep_i(sleep_i), .mode_o(mode_nx));

  adc_pwr_edge #(.IDLE_VAL(1'b1)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (start_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_pwr_fsm #(
    .PWRUP_CYC (PWRUP_CYC),
    .CONV_CYC  (CONV_CYC),
    .CAL_CYC   (CAL_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cal_dis_i    (cal_dis_i),
    .mode_q_i     (mode_q),
    .mode_nx_i    (mode_nx),
    .wr_valid_i   (wr_valid_i),
    .wr_conv_i    (wr_conv_i),
    .wr_cal_i     (wr_cal_i),
    .rise_i       (rise),
    .fall_i       (fall),
    .pwr_up_o     (pwr_up_o),
    .ref_en_o     (ref_en_o),
    .conv_start_o (conv_start_o),
    .busy_o       (busy_o),
    .cal_o        (cal_o),
    .err_o        (err_o)
  );
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_valid_i,
  input logic [1:0] pm_i,
  input logic       pwr_up_o,
  input logic       ref_en_o,
  input logic       conv_start_o,
  input logic       busy_o,
  input logic       cal_o,
  input logic       err_o
);
  a_r7_ref_off_means_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_en_o |-> !pwr_up_o);

  a_r5_start_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (busy_o && pwr_up_o));

  a_r5_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  a_r5_busy_rise_has_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> conv_start_o);

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !wr_valid_i) |=> err_o);

  a_r8_forced_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_i == 2'b10 && !busy_o && !cal_o) |-> !pwr_up_o);

  a_r1_cal_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> (pwr_up_o && !busy_o));

  a_r6_part_drop_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(pm_i == 2'b11) && !$past(wr_valid_i)) |-> !pwr_up_o);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .pm_i         (pm_q),
  .pwr_up_o     (pwr_up_o),
  .ref_en_o     (ref_en_o),
  .conv_start_o (conv_start_o),
  .busy_o       (busy_o),
  .cal_o        (cal_o),
  .err_o        (err_o)
);

// File: tb/adc_pwr_seq_tb.sv
module adc_pwr_seq_tb;
  localparam int P   = 8;
  localparam int C   = 5;
  localparam int CAL = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid_i = 1'b0;
  logic [1:0] wr_pm_i = 2'b00;
  logic wr_conv_i = 1'b0, wr_cal_i = 1'b0;
  logic sleep_i = 1'b0, start_i = 1'b1, cal_dis_i = 1'b0;
  logic pwr_up_o, ref_en_o, conv_start_o, busy_o, cal_o, err_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  adc_pwr_seq #(.PWRUP_CYC(P), .CONV_CYC(C), .CAL_CYC(CAL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_pm_i(wr_pm_i),
    .wr_conv_i(wr_conv_i), .wr_cal_i(wr_cal_i), .sleep_i(sleep_i),
    .start_i(start_i), .cal_dis_i(cal_dis_i), .pwr_up_o(pwr_up_o),
    .ref_en_o(ref_en_o), .conv_start_o(conv_start_o), .busy_o(busy_o),
    .cal_o(cal_o), .err_o(err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] pm, input logic cv, input logic cl);
    wr_valid_i = 1'b1; wr_pm_i = pm; wr_conv_i = cv; wr_cal_i = cl;
    @(negedge clk);
    wr_valid_i = 1'b0; wr_conv_i = 1'b0; wr_cal_i = 1'b0;
  endtask

  // returns number of busy cycles, ends on first negedge with busy low
  task automatic count_busy(output int n);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      if (n == 2) chk("R5 start pulse width", conv_start_o, 0);
      @(negedge clk);
    end
  endtask

  task automatic cycle_conv(input string req);
    int n;
    start_i = 1'b0;
    @(negedge clk);
    chk({req, " wake after fall"}, pwr_up_o, 1);
    chk({req, " no busy in wake"}, busy_o, 0);
    repeat (P) @(negedge clk);
    chk({req, " powered after wake"}, pwr_up_o, 1);
    start_i = 1'b1;
    @(negedge clk);
    chk("R5 conv_start pulse", conv_start_o, 1);
    chk("R5 busy asserted", busy_o, 1);
    count_busy(n);
    chk("R5 busy length", n, C);
  endtask

  task automatic t_reset_cal();
    int n;
    cal_dis_i = 1'b0; rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset pwr_up", pwr_up_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset ref_en field 00", ref_en_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    n = 0;
    while (cal_o && n < 1000) begin
      n++;
      if (n == 3) begin sleep_i = 1'b1; start_i = 1'b0; end
      if (n == 8) begin sleep_i = 1'b0; start_i = 1'b1; end
      if (n == 10) chk("R1 powered during cal", pwr_up_o, 1);
      @(negedge clk);
    end
    chk("R1 cal length", n, CAL);
    chk("R1 down after cal", pwr_up_o, 0);
    chk("R1 ref off after cal", ref_en_o, 0);
  endtask

  task automatic t_full_cycle();
    cycle_conv("R4");
    chk("R6 power drop with busy", pwr_up_o, 0);
    chk("R7 ref off full down", ref_en_o, 0);
  endtask

  task automatic t_early_edge();
    start_i = 1'b0;
    @(negedge clk);
    repeat (P - 1) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    chk("R9 err set", err_o, 1);
    chk("R9 no conversion", busy_o, 0);
    repeat (3) @(negedge clk);
    chk("R9 still no conversion", busy_o, 0);
    chk("R9 err sticky", err_o, 1);
    wr(2'b00, 1'b0, 1'b0);
    chk("R9 err cleared by write", err_o, 0);
    chk("R4 write of cycling mode powers down", pwr_up_o, 0);
  endtask

  task automatic t_partial();
    wr(2'b11, 1'b0, 1'b0);
    chk("R7 partial down pwr", pwr_up_o, 0);
    chk("R7 partial down ref", ref_en_o, 1);
    cycle_conv("R4 partial");
    chk("R6 partial drop", pwr_up_o, 0);
    chk("R7 ref kept on", ref_en_o, 1);
  endtask

  task automatic t_always_on();
    int n;
    wr(2'b01, 1'b0, 1'b0);
    chk("R3 wake on field 01", pwr_up_o, 1);
    repeat (P) @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    chk("R3 convert when on", busy_o, 1);
    count_busy(n);
    chk("R3 busy length", n, C);
    chk("R3 stays powered", pwr_up_o, 1);
    sleep_i = 1'b1;
    @(negedge clk);
    wr(2'b00, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R3 field 00 sleep high powered", pwr_up_o, 1);
    sleep_i = 1'b0;
    @(negedge clk);
    wr(2'b00, 1'b0, 1'b0);
    chk("R3 sleep low then write powers down", pwr_up_o, 0);
  endtask

  task automatic t_sw_conv();
    int n;
    int bad;
    wr(2'b01, 1'b1, 1'b0);
    chk("R10 command while down ignored", busy_o, 0);
    bad = 0;
    for (int i = 0; i < P; i++) begin
      if (busy_o) bad++;
      @(negedge clk);
    end
    chk("R10 no busy during wake", bad, 0);
    wr(2'b01, 1'b1, 1'b0);
    chk("R10 conv_start from write", conv_start_o, 1);
    chk("R10 busy from write", busy_o, 1);
    count_busy(n);
    chk("R10 busy length", n, C);
  endtask

  task automatic t_forced_down();
    int bad;
    wr(2'b10, 1'b0, 1'b0);
    chk("R8 forced down pwr", pwr_up_o, 0);
    chk("R8 forced down ref", ref_en_o, 0);
    bad = 0;
    start_i = 1'b0;
    for (int i = 0; i < P + 1; i++) begin
      @(negedge clk);
      if (pwr_up_o) bad++;
    end
    start_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (pwr_up_o || busy_o) bad++;
    end
    chk("R8 pin ignored", bad, 0);
    wr(2'b10, 1'b1, 1'b0);
    chk("R8 sw conv ignored", busy_o, 0);
    wr(2'b10, 1'b0, 1'b1);
    chk("R8 sw cal ignored", cal_o, 0);
  endtask

  task automatic t_sw_cal_partial();
    int n;
    wr(2'b01, 1'b0, 1'b0);
    repeat (P + 1) @(negedge clk);
    wr(2'b11, 1'b0, 1'b1);
    n = 0;
    while (cal_o && n < 1000) begin n++; @(negedge clk); end
    chk("R11 cal length", n, CAL);
    chk("R11 powered after cal", pwr_up_o, 1);
    repeat (5) @(negedge clk);
    chk("R11 still powered", pwr_up_o, 1);
    wr(2'b11, 1'b0, 1'b0);
    chk("R11 write powers down", pwr_up_o, 0);
    chk("R11 ref kept", ref_en_o, 1);
  endtask

  task automatic t_cal_skip();
    rst_ni = 1'b0; cal_dis_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 no cal", cal_o, 0);
    chk("R2 down", pwr_up_o, 0);
    repeat (3) @(negedge clk);
    chk("R2 stays down", pwr_up_o, 0);
    chk("R1 field back to 00 ref off", ref_en_o, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset_cal();
    t_full_cycle();
    t_early_edge();
    t_partial();
    t_always_on();
    t_sw_conv();
    t_forced_down();
    t_sw_cal_partial();
    t_cal_skip();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule